// File: doc/BRIEF.md
# Block-Serial Class-Star Marker Engine

This engine looks for one fixed three-part pattern in a character stream that arrives one block of positions per clock. The pattern is a single leading class, then any number of characters from a repeated class, then one closing class. The engine does not see characters. Each block brings three class streams, one bit per text position, that an upstream decoder has already computed. Bit 0 of a block is the earliest text position in that block. The engine returns three marker streams. A marker bit always sits on the position just after the last character matched. The engine also raises a flag when a block contains at least one complete match.

The repeated-class step is done in a single pass over the block. It adds the class stream to the markers that land on that class, XORs the sum with the class stream, and ORs back the original markers. Because carries move toward later positions, the result marks every position reachable through zero or more class characters, not only the end of the longest run, so ambiguous text reports all of its matches. The carry out of the addition and the top bit pushed out by each one-position advance are kept in registers and fed into the next block. A match that spans a block boundary is therefore found exactly as if the whole stream were one wide word.

A small controller has two states. `ST_IDLE` is entered at reset and accepts no blocks. A start-of-stream pulse moves it to `ST_RUN`, where one block is taken on every cycle that valid is high. A pulse in `ST_RUN` stays in `ST_RUN` and restarts the stream. Results appear one cycle after a block is taken.

Top module: `mse_marker_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid_o`, `m1_o`, `m2_o`, `m3_o`, `match_o` and `blk_ready_o` are all 0.
- R2: The controller leaves `ST_IDLE` only on `sos_i`. `blk_ready_o` is 0 in `ST_IDLE` and goes to 1 on the cycle after the pulse. Blocks offered in `ST_IDLE` are dropped.
- R3: `m1_o` is the leading-class stream moved up by one position. Bit 0 of `m1_o` is the top leading-class bit of the block taken before it in the same stream.
- R4: `m2_o` marks exactly the positions reachable from an `m1_o` marker through zero or more repeated-class characters. This includes every position inside a run, not only the end of the longest run, and `m2_o` therefore always covers `m1_o`.
- R5: A repeated-class run that crosses one or more block boundaries keeps extending the `m2_o` markers into later blocks, including across a block whose class bits are all 1.
- R6: `m3_o` is (`m2_o` AND closing class) moved up by one position. Its top bit is carried into bit 0 of the next block's `m3_o`.
- R7: `match_o` is 1 exactly when at least one bit of `m3_o` is 1.
- R8: When no block is taken, `out_valid_o` is 0 on the next cycle and the marker outputs and saved carries do not change.
- R9: A block taken at a clock edge produces its results, with `out_valid_o` at 1, after that edge.
- R10: `sos_i` clears every saved carry and shift bit. A block offered together with the pulse in `ST_RUN` is processed as the first block of a new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sos_i | input | 1 | Start-of-stream pulse |
| blk_valid_i | input | 1 | A block is offered |
| blk_ready_o | output | 1 | Engine can take a block (state `ST_RUN`) |
| lit_cls_i | input | BLK_W | Leading-class bits, bit 0 = earliest position |
| star_cls_i | input | BLK_W | Repeated-class bits |
| fin_cls_i | input | BLK_W | Closing-class bits |
| out_valid_o | output | 1 | Results below belong to a block taken last cycle |
| m1_o | output | BLK_W | Markers after the leading class |
| m2_o | output | BLK_W | Markers after zero or more repeated-class characters |
| m3_o | output | BLK_W | Markers after the closing class |
| match_o | output | 1 | At least one complete match ends in this block |

## Verification
The bench feeds a short text of letters, digits and dashes, with digits as the repeated class. Its digit runs and ambiguous tails cross block edges, which separates a correct all-positions result from a longest-run-only result and from dropped carries. Blocks whose repeated class is all 1 make a carry pass through a whole block. Random dense class patterns with stalls in between exercise many carry and shift combinations, and check that a stall leaves state untouched. A restart in the middle of a stream, with and without a block on the same cycle, shows whether old carries leak into the new stream.

// File: rtl/mse_pkg.sv
package mse_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mse_state_e;
endpackage

// File: rtl/mse_advance.sv
// Moves a stream one position toward later text; the top bit leaves as cout.
module mse_advance #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         cin,
    output logic [W-1:0] dout,
    output logic         cout
);
    always_comb begin
        dout = {din[W-2:0], cin};
        cout = din[W-1];
    end
endmodule

// File: rtl/mse_star_add.sv
// Class-star closure of one block: ((M & C) + C + cin) ^ C | M.
module mse_star_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] mrk,
    input  logic [W-1:0] cls,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int SW = W + 1;
    logic [SW-1:0] sum;

    always_comb begin
        sum  = {1'b0, mrk & cls} + {1'b0, cls} + {{W{1'b0}}, cin};
        res  = (sum[W-1:0] ^ cls) | mrk;
        cout = sum[W];
    end
endmodule

// File: rtl/mse_ctrl.sv
module mse_ctrl
    import mse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sos_i,
    output logic ready_o
);
    mse_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (sos_i) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        ready_o = (state == ST_RUN);
    end

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !sos_i) |=> !ready_o);
    assert_pulse_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sos_i |=> ready_o);
endmodule

// File: rtl/mse_marker_engine.sv
module mse_marker_engine #(
    parameter int BLK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sos_i,
    input  logic             blk_valid_i,
    output logic             blk_ready_o,
    input  logic [BLK_W-1:0] lit_cls_i,
    input  logic [BLK_W-1:0] star_cls_i,
    input  logic [BLK_W-1:0] fin_cls_i,
    output logic             out_valid_o,
    output logic [BLK_W-1:0] m1_o,
    output logic [BLK_W-1:0] m2_o,
    output logic [BLK_W-1:0] m3_o,
    output logic             match_o
);
    logic             acc;
    logic             sv_lit, sv_add, sv_fin;
    logic             in_lit, in_add, in_fin;
    logic             nx_lit, nx_add, nx_fin;
    logic [BLK_W-1:0] m1_n, m2_n, m3_n, gate_n;

    mse_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sos_i   (sos_i),
        .ready_o (blk_ready_o)
    );

    always_comb begin
        acc    = blk_valid_i && blk_ready_o;
        in_lit = sos_i ? 1'b0 : sv_lit;
        in_add = sos_i ? 1'b0 : sv_add;
        in_fin = sos_i ? 1'b0 : sv_fin;
        gate_n = m2_n & fin_cls_i;
    end

    mse_advance #(.W(BLK_W)) u_adv_lit (
        .din  (lit_cls_i),
        .cin  (in_lit),
        .dout (m1_n),
        .cout (nx_lit)
    );

    mse_star_add #(.W(BLK_W)) u_star (
        .mrk  (m1_n),
        .cls  (star_cls_i),
        .cin  (in_add),
        .res  (m2_n),
        .cout (nx_add)
    );

    mse_advance #(.W(BLK_W)) u_adv_fin (
        .din  (gate_n),
        .cin  (in_fin),
        .dout (m3_n),
        .cout (nx_fin)
    );

    // Saved carries: updated by a taken block, cleared by a lone restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_lit <= 1'b0;
            sv_add <= 1'b0;
            sv_fin <= 1'b0;
        end else if (acc) begin
            sv_lit <= nx_lit;
            sv_add <= nx_add;
            sv_fin <= nx_fin;
        end else if (sos_i) begin
            sv_lit <= 1'b0;
            sv_add <= 1'b0;
            sv_fin <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            m1_o        <= '0;
            m2_o        <= '0;
            m3_o        <= '0;
            match_o     <= 1'b0;
        end else begin
            out_valid_o <= acc;
            if (acc) begin
                m1_o    <= m1_n;
                m2_o    <= m2_n;
                m3_o    <= m3_n;
                match_o <= |m3_n;
            end
        end
    end

    assert_stall_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !out_valid_o);
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(m2_o) && $stable(m3_o)));
    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid_o);
    assert_m2_covers_m1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((m1_o & ~m2_o) == '0));
    assert_flag_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (match_o == (|m3_o)));
    assert_restart_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sos_i) |=> (!m1_o[0] && !m3_o[0]));
endmodule

// File: tb/mse_marker_engine_tb.sv
`timescale 1ns/1ps
module mse_marker_engine_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sos = 1'b0;
    logic         valid = 1'b0;
    logic [W-1:0] lit = '0, star = '0, fin = '0;
    logic         ready, ov, match;
    logic [W-1:0] m1, m2, m3;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    bit           exp_ready = 0;
    bit           pl = 0, pm = 0, pf = 0;
    logic [W-1:0] e1 = '0, e2 = '0, e3 = '0;
    bit           em = 0;

    always #10 clk = ~clk;

    mse_marker_engine #(.BLK_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sos_i(sos), .blk_valid_i(valid),
        .blk_ready_o(ready), .lit_cls_i(lit), .star_cls_i(star),
        .fin_cls_i(fin), .out_valid_o(ov), .m1_o(m1), .m2_o(m2),
        .m3_o(m3), .match_o(match)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Position-by-position reachability, independent of any adder.
    task automatic model_blk(input logic [W-1:0] l, input logic [W-1:0] s, input logic [W-1:0] f);
        logic [W-1:0] a, b, c;
        for (int p = 0; p < W; p++) begin
            a[p] = (p == 0) ? pl : l[p-1];
            b[p] = a[p] | ((p == 0) ? pm : (b[p-1] & s[p-1]));
        end
        for (int p = 0; p < W; p++)
            c[p] = (p == 0) ? pf : (b[p-1] & f[p-1]);
        pl = l[W-1];
        pm = b[W-1] & s[W-1];
        pf = b[W-1] & f[W-1];
        e1 = a; e2 = b; e3 = c; em = |c;
    endtask

    task automatic step(input bit s, input bit v, input logic [W-1:0] l,
                        input logic [W-1:0] st, input logic [W-1:0] f, input string tag);
        bit acc;
        sos = s; valid = v; lit = l; star = st; fin = f;
        chk(ready == exp_ready, "R2 ready", ready, exp_ready);
        acc = v && exp_ready;
        if (s) begin pl = 0; pm = 0; pf = 0; end
        if (acc) model_blk(l, st, f);
        if (s) exp_ready = 1;
        @(negedge clk);
        chk(ov == acc, {tag, " R9 valid"}, ov, acc);
        chk(m1 == e1, {tag, " R3 m1"}, m1, e1);
        chk(m2 == e2, {tag, " R4 m2"}, m2, e2);
        chk(m3 == e3, {tag, " R6 m3"}, m3, e3);
        chk(match == em, {tag, " R7 flag"}, match, em);
    endtask

    function automatic logic [W-1:0] cls_of(input string t, input int base, input int kind);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            byte ch;
            ch = t[base + i];
            case (kind)
                0: r[i] = (ch == "a");
                1: r[i] = (ch >= "0" && ch <= "9");
                default: r[i] = (ch == "z" || ch == "9");
            endcase
        end
        return r;
    endfunction

    initial begin
        string txt;
        txt = "a453z--b3z--az--a12949z--ca22z7--a99999999999999999999999999999999z----";
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!ov && m1 == 0 && m2 == 0 && m3 == 0 && !match && !ready, "R1 reset", {ov, match, ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ov && !ready && m2 == 0, "R1 after reset", {ov, ready}, 0);
        // R2: blocks dropped in idle
        step(0, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R2 idle drop");
        step(1, 0, '0, '0, '0, "R2 start");
        // Text across blocks (R3 R4 R5 R6 R7)
        for (int b = 0; b < 4; b++)
            step(0, 1, cls_of(txt, b*W, 0), cls_of(txt, b*W, 1), cls_of(txt, b*W, 2), "text R5");
        // R8 stall between blocks
        step(0, 0, 16'h1234, 16'hFFFF, 16'hFFFF, "R8 stall");
        // R5: full-ones star blocks carry through
        step(0, 1, 16'h8000, 16'h8000, 16'h0000, "R5 seed");
        step(0, 1, 16'h0000, 16'hFFFF, 16'h0000, "R5 all ones");
        step(0, 0, 16'h0000, 16'h0000, 16'h0000, "R8 stall");
        step(0, 1, 16'h0000, 16'h00FF, 16'h0100, "R5 tail");
        // R10 restart with block while carries pending
        step(0, 1, 16'h8000, 16'h8000, 16'h8000, "R10 prime");
        step(1, 1, 16'h0000, 16'hFFFF, 16'hFFFF, "R10 restart");
        step(0, 1, 16'h8000, 16'hFFFF, 16'h8000, "R10 prime2");
        step(1, 0, 16'h0000, 16'h0000, 16'h0000, "R10 lone");
        step(0, 1, 16'h0000, 16'hFFFF, 16'hFFFF, "R10 after");
        // random dense patterns with stalls
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] rl, rs, rf;
            rl = W'($urandom); rs = W'($urandom) | W'($urandom); rf = W'($urandom);
            step((k % 97) == 50, ($urandom % 4) != 0, rl, rs, rf, "random R4");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule